// File: doc/BRIEF.md
# Switching Protection Supervisor

This block is the state machine that decides whether a switching power converter may drive its power switch. It reads six comparator flags that are already digital and synchronised. Two describe the supply: it is above the start level, or it is at or below the stop level. One reports supply overvoltage and one reports current-sense overcurrent. The last two report die temperature: too hot, or cooled back down. From these flags it produces a registered switch-enable and a 3-bit code for its current state.

The supply levels form an undervoltage lockout with hysteresis. Overcurrent and overvoltage faults latch the block off. Such a latch is released only by a full supply dip to the stop level, and restart then needs a fresh rise past the start level. A thermal fault recovers without help once the die has cooled. Every flag except overcurrent must be seen at two consecutive clock edges before it takes effect, which rejects single-cycle glitches. Overcurrent takes effect at the first edge that sees it.

Top module: `prot_supervisor`

## Requirements
- R1: After reset the state code is 0 (supply off) and `sw_en` is 0.
- R2: In the supply-off state (code 0), a qualified start flag moves the block to running (code 1) at the next edge, provided there is no qualified low flag, no overvoltage, no over-temperature and no raw overcurrent. If any of these fault flags is present, the block stays in code 0 and latches nothing.
- R3: A qualified low flag moves the block from any state to supply-off (code 0) at the next edge. It takes precedence over every other flag.
- R4: In running (code 1) or thermal (code 4), a raw `ocp_flag` seen at a single edge moves the block to the overcurrent latch (code 2) at that same edge.
- R5: In running or thermal, a qualified overvoltage flag moves the block to the overvoltage latch (code 3).
- R6: Codes 2 and 3 are left only for code 0, and only on a qualified low flag. Every other flag, including start, is ignored while latched.
- R7: In running, a qualified hot flag moves the block to thermal (code 4). In thermal, a qualified cool flag moves it back to running, unless a higher-priority flag applies.
- R8: When several flags apply in the same cycle, the order of precedence is low supply, then overcurrent, then overvoltage, then temperature.
- R9: A flag other than overcurrent is qualified only when it is high at two consecutive clock edges. A flag that is high at one edge only has no effect.
- R10: `sw_en` is a register that changes at the same edge as the state code. It is 1 exactly when the code is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_flag | input | 1 | Supply above start level |
| low_flag | input | 1 | Supply at or below stop level |
| ovp_flag | input | 1 | Supply overvoltage |
| ocp_flag | input | 1 | Current-sense overcurrent |
| hot_flag | input | 1 | Die over-temperature |
| cool_flag | input | 1 | Die cooled below recovery level |
| sw_en | output | 1 | Switching allowed |
| state_code | output | 3 | 0 off, 1 run, 2 overcurrent latch, 3 overvoltage latch, 4 thermal |

## Verification
The bench places the block in each of the five states. From each state it applies all 64 flag combinations, once held for two edges and once as a one-edge glitch. A predictor built from the requirements gives the expected code and enable.

The sweep targets four kinds of fault:
- A broken glitch filter would jump states on a one-edge pulse.
- An overcurrent path given the two-edge filter would reach the latch one edge late.
- A latch that listened to the start flag would resume switching without the supply dip.
- A wrong precedence order would latch a fault when a low supply should have won.

// File: rtl/prot_supervisor.sv
module prot_supervisor (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_flag,
  input  logic       low_flag,
  input  logic       ovp_flag,
  input  logic       ocp_flag,
  input  logic       hot_flag,
  input  logic       cool_flag,
  output logic       sw_en,
  output logic [2:0] state_code
);

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_RUN  = 3'd1,
    ST_OCP  = 3'd2,
    ST_OVP  = 3'd3,
    ST_HEAT = 3'd4
  } state_t;

  state_t state, nxt;
  logic [4:0] raw, seen;
  logic start_ok, low_ok, ovp_ok, hot_ok, cool_ok;

  assign raw = {cool_flag, hot_flag, ovp_flag, low_flag, start_flag};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= '0;
    else        seen <= raw;

  assign {cool_ok, hot_ok, ovp_ok, low_ok, start_ok} = raw & seen;

  always_comb begin
    nxt = state;
    case (state)
      ST_OFF:
        if (!low_ok && start_ok && !ocp_flag && !ovp_ok && !hot_ok) nxt = ST_RUN;
      ST_RUN:
        if (low_ok)        nxt = ST_OFF;
        else if (ocp_flag) nxt = ST_OCP;
        else if (ovp_ok)   nxt = ST_OVP;
        else if (hot_ok)   nxt = ST_HEAT;
      ST_OCP, ST_OVP:
        if (low_ok) nxt = ST_OFF;
      ST_HEAT:
        if (low_ok)        nxt = ST_OFF;
        else if (ocp_flag) nxt = ST_OCP;
        else if (ovp_ok)   nxt = ST_OVP;
        else if (cool_ok)  nxt = ST_RUN;
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_OFF;
      sw_en <= 1'b0;
    end else begin
      state <= nxt;
      sw_en <= (nxt == ST_RUN);
    end

  assign state_code = state;

  // R3
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_ok |=> (state_code == 3'd0 && !sw_en));

  // R4
  ocp_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RUN || state == ST_HEAT) && ocp_flag && !low_ok) |=> (state_code == 3'd2 && !sw_en));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_OCP || state == ST_OVP) && !low_ok) |=> $stable(state_code));

  // R7
  heat_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HEAT && cool_ok && !low_ok && !ocp_flag && !ovp_ok) |=> sw_en);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && start_ok && !low_ok && !ocp_flag && !ovp_ok && !hot_ok) |=> (sw_en && state_code == 3'd1));

endmodule

// File: tb/prot_supervisor_bench.sv
module prot_supervisor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] v = '0;
  logic sw_en;
  logic [2:0] state_code;
  int checks = 0, fails = 0;
  logic [5:0] prev = '0;
  logic [2:0] exp_st = 3'd0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prot_supervisor u_prot_supervisor (
    .clk(clk), .rst_n(rst_n),
    .start_flag(v[0]), .low_flag(v[1]), .ovp_flag(v[2]),
    .ocp_flag(v[3]), .hot_flag(v[4]), .cool_flag(v[5]),
    .sw_en(sw_en), .state_code(state_code)
  );

  function automatic logic [2:0] model(input logic [2:0] st, input logic [5:0] q, input logic ocp);
    logic start, low, ovp, hot, cool;
    {cool, hot, ovp, low, start} = {q[5], q[4], q[2], q[1], q[0]};
    if (low) return 3'd0;
    case (st)
      3'd0: return (start && !ocp && !ovp && !hot) ? 3'd1 : 3'd0;
      3'd1: return ocp ? 3'd2 : ovp ? 3'd3 : hot ? 3'd4 : 3'd1;
      3'd4: return ocp ? 3'd2 : ovp ? 3'd3 : cool ? 3'd1 : 3'd4;
      default: return st;
    endcase
  endfunction

  task automatic edge_with(input logic [5:0] nv);
    v = nv;
    @(posedge clk);
    #1;
    exp_st = model(exp_st, nv & prev, nv[3]);
    prev = nv;
  endtask

  task automatic check(input string req);
    checks++;
    if (state_code !== exp_st || sw_en !== (exp_st == 3'd1)) begin
      fails++;
      $display("FAIL %s: code=%0d en=%0b expected code=%0d en=%0b",
               req, state_code, sw_en, exp_st, exp_st == 3'd1);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; v = '0; prev = '0; exp_st = 3'd0;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    check("R1");
    for (int st = 0; st < 5; st++) begin
      for (int combo = 0; combo < 64; combo++) begin
        for (int glitch = 0; glitch < 2; glitch++) begin
          logic [5:0] neutral;
          do_reset();
          neutral = (st == 0) ? 6'b000000 : 6'b000001;
          if (st != 0) begin
            edge_with(6'b000001); edge_with(6'b000001);
          end
          if (st == 2) edge_with(6'b001001);
          if (st == 3) begin edge_with(6'b000101); edge_with(6'b000101); end
          if (st == 4) begin edge_with(6'b010001); edge_with(6'b010001); end
          edge_with(neutral); edge_with(neutral);
          check("R2 setup");
          if (state_code == 3'(st)) begin
            edge_with(6'(combo));
            check("R4 first edge");
            edge_with(glitch ? neutral : 6'(combo));
            if (glitch) check("R9 glitch rejected");
            else if (combo[1]) check("R3");
            else if (st == 2 || st == 3) check("R6");
            else if (combo[3]) check("R8");
            else if (combo[2]) check("R5");
            else if (st == 4 || combo[4]) check("R7");
            else check("R10");
          end
        end
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule